// File: doc/BRIEF.md
# Bit-serial windowed mean and mean-square engine

This block takes a stream of signed fixed-point samples (3 integer bits and 28 fraction bits, 32 bits in all) and reports, once per window of F = 2^LOG2_F samples, the average of the window and the average of the squared samples. Samples are sparse: a new one arrives at most once every SAMPLE_PERIOD fast clocks (1024 by default). The block uses that gap to do all of its arithmetic bit by bit instead of with wide parallel adders.

For each accepted sample, a shift-and-add squarer forms the exact 64-bit square, one partial product per clock. Then two serial accumulators, each built around a single full adder with a held carry, add the sign-extended sample into a 48-bit running sum and the square into an 80-bit running sum, least significant bit first. When the last sample of a window has been added, the upper bits of both sums are registered as the results. Dividing by F is only a change in where the binary point sits, so no divider is needed. The block raises a one-clock done pulse and clears both sums, and the next window starts from zero.

Top module: `window_stats`

## Requirements
- R1: After reset, mean_out and msq_out are zero, window_done is low and busy is low.
- R2: At each window_done, mean_out equals bits [DATA_W+LOG2_F-1 : LOG2_F] of the two's-complement sum of the window's F samples, each sign-extended to DATA_W+LOG2_F bits. This is the sum divided by F, rounded toward minus infinity.
- R3: At each window_done, msq_out equals bits [2*DATA_W+LOG2_F-1 : LOG2_F] of the sum of the F exact squares. This value is never negative (bit 63 is 0).
- R4: Full-scale windows do not overflow. F samples of 0x7FFFFFFF give a mean of 0x7FFFFFFF. F samples of 0x80000000 give a mean of 0x80000000 and a mean-square of 0x4000000000000000.
- R5: window_done is high for exactly one clock after the F-th sample of a window has been processed, it is never high after any other sample, and busy is low while it is high.
- R6: busy rises in the clock after sample_valid is accepted and falls within SAMPLE_PERIOD clocks. A sample spaced SAMPLE_PERIOD or more clocks after the previous one always finds busy low.
- R7: Both sums start the next window from zero, so each window's results depend only on that window's samples, including the window that follows a full-scale one.
- R8: mean_out and msq_out keep their values between window_done pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_valid | input | 1 | One-clock strobe, sample_in holds a new sample |
| sample_in | input | DATA_W | Signed sample, 3 integer and 28 fraction bits |
| mean_out | output | DATA_W | Window mean, same format as the input |
| msq_out | output | 2*DATA_W | Window mean-square, 7 integer and 56 fraction bits |
| window_done | output | 1 | One-clock pulse when new results are registered |
| busy | output | 1 | A sample is being squared or accumulated |

## Verification
The checker watches every cycle for the properties that need no arithmetic. These are the single-clock done pulse, done only while idle, outputs held between pulses, a non-negative mean-square, the per-sample processing time staying below the sample period, and no sample arriving while busy. The numeric results can only be shown by the bench's scenarios. It runs whole windows of full-scale positive and negative values, zeros, alternating signs, small negative values that exercise the floor rounding, and pseudo-random values. It compares each result with sums it computes itself, and this also shows that one window does not leak into the next.

// File: rtl/stats_pkg.sv
package stats_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SQUARE = 2'd1,
        PH_ACCUM  = 2'd2
    } phase_t;

    typedef struct packed {
        logic carry;
        logic sum;
    } fa_out_t;

    function automatic fa_out_t full_add(input logic a, input logic b, input logic cin);
        fa_out_t r;
        r.sum   = a ^ b ^ cin;
        r.carry = (a & b) | (a & cin) | (b & cin);
        return r;
    endfunction

endpackage

// File: rtl/serial_accum.sv
module serial_accum
    import stats_pkg::*;
#(
    parameter int IN_W = 32,
    parameter int W    = 48
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clr,
    input  logic            start,
    input  logic [IN_W-1:0] operand,
    output logic            busy,
    output logic [W-1:0]    total
);
    localparam int CW = (W > 1) ? $clog2(W) : 1;

    logic [W-1:0]  acc_q;
    logic [W-1:0]  opnd_q;
    logic          carry_q;
    logic [CW-1:0] bit_cnt;
    logic          busy_q;
    fa_out_t       fa;

    assign fa = full_add(acc_q[0], opnd_q[0], carry_q);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            acc_q   <= '0;
            opnd_q  <= '0;
            carry_q <= 1'b0;
            bit_cnt <= '0;
            busy_q  <= 1'b0;
        end else if (start) begin
            opnd_q  <= {{(W-IN_W){operand[IN_W-1]}}, operand};
            carry_q <= 1'b0;
            bit_cnt <= '0;
            busy_q  <= 1'b1;
        end else if (busy_q) begin
            acc_q   <= {fa.sum, acc_q[W-1:1]};
            opnd_q  <= {1'b0, opnd_q[W-1:1]};
            carry_q <= fa.carry;
            bit_cnt <= bit_cnt + 1'b1;
            if (bit_cnt == CW'(W-1))
                busy_q <= 1'b0;
        end
    end

    assign busy  = busy_q;
    assign total = acc_q;
endmodule

// File: rtl/serial_squarer.sv
module serial_squarer #(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [W-1:0]   sample,
    output logic           busy,
    output logic [2*W-1:0] square
);
    localparam int CW = (W > 1) ? $clog2(W) : 1;

    logic [W-1:0]   mag;
    logic [2*W-1:0] mcand_q;
    logic [W-1:0]   mplier_q;
    logic [2*W-1:0] prod_q;
    logic [CW-1:0]  step;
    logic           busy_q;

    assign mag = sample[W-1] ? (~sample + 1'b1) : sample;

    always_ff @(posedge clk) begin
        if (rst) begin
            mcand_q  <= '0;
            mplier_q <= '0;
            prod_q   <= '0;
            step     <= '0;
            busy_q   <= 1'b0;
        end else if (start) begin
            mcand_q  <= {{W{1'b0}}, mag};
            mplier_q <= mag;
            prod_q   <= '0;
            step     <= '0;
            busy_q   <= 1'b1;
        end else if (busy_q) begin
            if (mplier_q[0])
                prod_q <= prod_q + mcand_q;
            mcand_q  <= {mcand_q[2*W-2:0], 1'b0};
            mplier_q <= {1'b0, mplier_q[W-1:1]};
            step     <= step + 1'b1;
            if (step == CW'(W-1))
                busy_q <= 1'b0;
        end
    end

    assign busy   = busy_q;
    assign square = prod_q;
endmodule

// File: rtl/window_stats.sv
module window_stats
    import stats_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LOG2_F = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                sample_valid,
    input  logic [DATA_W-1:0]   sample_in,
    output logic [DATA_W-1:0]   mean_out,
    output logic [2*DATA_W-1:0] msq_out,
    output logic                window_done,
    output logic                busy
);
    localparam int MEAN_ACC_W = DATA_W + LOG2_F;
    localparam int SQ_W       = 2 * DATA_W;
    localparam int SQ_ACC_W   = SQ_W + LOG2_F;

    phase_t              phase;
    logic [DATA_W-1:0]   sample_q;
    logic [LOG2_F-1:0]   count;
    logic                sq_start, acc_start, acc_clr;
    logic                sq_busy, m_busy, s_busy;
    logic [SQ_W-1:0]     square;
    logic [MEAN_ACC_W-1:0] m_total;
    logic [SQ_ACC_W-1:0]   s_total;

    serial_squarer #(.W(DATA_W)) u_sq (
        .clk(clk), .rst(rst), .start(sq_start), .sample(sample_q),
        .busy(sq_busy), .square(square)
    );

    serial_accum #(.IN_W(DATA_W), .W(MEAN_ACC_W)) u_mean_acc (
        .clk(clk), .rst(rst), .clr(acc_clr), .start(acc_start),
        .operand(sample_q), .busy(m_busy), .total(m_total)
    );

    serial_accum #(.IN_W(SQ_W), .W(SQ_ACC_W)) u_sq_acc (
        .clk(clk), .rst(rst), .clr(acc_clr), .start(acc_start),
        .operand(square), .busy(s_busy), .total(s_total)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase       <= PH_IDLE;
            sample_q    <= '0;
            count       <= '0;
            sq_start    <= 1'b0;
            acc_start   <= 1'b0;
            acc_clr     <= 1'b0;
            mean_out    <= '0;
            msq_out     <= '0;
            window_done <= 1'b0;
        end else begin
            sq_start    <= 1'b0;
            acc_start   <= 1'b0;
            acc_clr     <= 1'b0;
            window_done <= 1'b0;
            unique case (phase)
                PH_IDLE: begin
                    if (sample_valid) begin
                        sample_q <= sample_in;
                        sq_start <= 1'b1;
                        phase    <= PH_SQUARE;
                    end
                end
                PH_SQUARE: begin
                    if (!sq_start && !sq_busy) begin
                        acc_start <= 1'b1;
                        phase     <= PH_ACCUM;
                    end
                end
                PH_ACCUM: begin
                    if (!acc_start && !m_busy && !s_busy) begin
                        phase <= PH_IDLE;
                        if (&count) begin
                            mean_out    <= m_total[MEAN_ACC_W-1:LOG2_F];
                            msq_out     <= s_total[SQ_ACC_W-1:LOG2_F];
                            window_done <= 1'b1;
                            acc_clr     <= 1'b1;
                            count       <= '0;
                        end else begin
                            count <= count + 1'b1;
                        end
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign busy = (phase != PH_IDLE);
endmodule

// File: rtl/window_stats_checker.sv
module window_stats_checker #(
    parameter int DATA_W        = 32,
    parameter int SAMPLE_PERIOD = 1024
) (
    input logic                clk,
    input logic                rst,
    input logic                sample_valid,
    input logic                busy,
    input logic                window_done,
    input logic [DATA_W-1:0]   mean_out,
    input logic [2*DATA_W-1:0] msq_out
);
    localparam int RW = $clog2(SAMPLE_PERIOD + 1) + 1;

    logic [RW-1:0] busy_run;

    always_ff @(posedge clk) begin
        if (rst)
            busy_run <= '0;
        else if (busy)
            busy_run <= (busy_run == {RW{1'b1}}) ? busy_run : busy_run + 1'b1;
        else
            busy_run <= '0;
    end

    p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!busy && !window_done && mean_out == '0 && msq_out == '0));

    p_msq_sign_r3: assert property (@(posedge clk) disable iff (rst)
        window_done |-> !msq_out[2*DATA_W-1]);

    p_done_single_r5: assert property (@(posedge clk) disable iff (rst)
        window_done |=> !window_done);

    p_done_idle_r5: assert property (@(posedge clk) disable iff (rst)
        window_done |-> !busy);

    p_slack_r6: assert property (@(posedge clk) disable iff (rst)
        busy_run < RW'(SAMPLE_PERIOD));

    p_no_overlap_r6: assert property (@(posedge clk) disable iff (rst)
        sample_valid |-> !busy);

    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !window_done |-> ($stable(mean_out) && $stable(msq_out)));
endmodule

bind window_stats window_stats_checker #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst(rst), .sample_valid(sample_valid), .busy(busy),
    .window_done(window_done), .mean_out(mean_out), .msq_out(msq_out)
);

// File: tb/window_stats_bench.sv
`timescale 1ns/1ps
module window_stats_bench;
    localparam int DW   = 32;
    localparam int LF   = 3;
    localparam int NS   = 1 << LF;
    localparam int MAW  = DW + LF;
    localparam int SQW  = 2 * DW;
    localparam int SAW  = SQW + LF;
    localparam int GAP  = 160;
    localparam int NWIN = 12;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           sample_valid = 1'b0;
    logic [DW-1:0]  sample_in = '0;
    logic [DW-1:0]  mean_out;
    logic [SQW-1:0] msq_out;
    logic           window_done;
    logic           busy;

    int checks = 0;
    int fails  = 0;

    logic [DW-1:0]  prev_mean = '0;
    logic [SQW-1:0] prev_msq  = '0;

    always #2.5 clk = ~clk;

    window_stats #(.DATA_W(DW), .LOG2_F(LF)) u_window_stats (
        .clk(clk), .rst(rst), .sample_valid(sample_valid), .sample_in(sample_in),
        .mean_out(mean_out), .msq_out(msq_out), .window_done(window_done), .busy(busy)
    );

    task automatic check(input bit ok, input string req, input logic [127:0] act,
                         input logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] gen(input int pat, input int i);
        logic [DW-1:0] v;
        case (pat)
            0:  v = 32'h7FFF_FFFF;
            1:  v = 32'h8000_0000;
            2:  v = 32'h0;
            3:  v = (i % 2 == 1) ? 32'h1000_0000 : 32'hF000_0000;
            4:  v = -(DW'(i) + 1);
            5:  v = DW'(i) * 32'h0123_4567 ^ 32'hA5A5_5A5A;
            default: v = DW'(pat * 32'h9E37_79B9 + i * 32'h6D2B_79F5) ^ (DW'(i) << 27);
        endcase
        return v;
    endfunction

    task automatic run_window(input int pat);
        logic [MAW-1:0] msum = '0;
        logic [SAW-1:0] ssum = '0;
        logic [SQW-1:0] sq;
        logic [DW-1:0]  s;
        logic [DW-1:0]  exp_mean;
        logic [SQW-1:0] exp_msq;
        int             seen = 0;
        bit             prev_done = 1'b0;
        for (int i = 0; i < NS; i++) begin
            s = gen(pat, i);
            msum = msum + {{LF{s[DW-1]}}, s};
            sq = {{DW{s[DW-1]}}, s} * {{DW{s[DW-1]}}, s};
            ssum = ssum + {{LF{1'b0}}, sq};
        end
        exp_mean = msum[MAW-1:LF];
        exp_msq  = ssum[SAW-1:LF];
        for (int i = 0; i < NS; i++) begin
            // R6: previous sample finished inside the sample gap
            check(busy == 1'b0, "R6 busy before sample", 128'(busy), 128'(0));
            sample_valid = 1'b1;
            sample_in    = gen(pat, i);
            @(negedge clk);
            sample_valid = 1'b0;
            check(busy == 1'b1, "R6 busy after accept", 128'(busy), 128'(1));
            for (int c = 1; c < GAP; c++) begin
                if (window_done) begin
                    seen++;
                    check(i == NS - 1, "R5 done only after last sample", 128'(i), 128'(NS - 1));
                    check(!prev_done, "R5 done one clock", 128'(prev_done), 128'(0));
                    check(mean_out == exp_mean, "R2 mean", 128'(mean_out), 128'(exp_mean));
                    check(msq_out == exp_msq, "R3 mean-square", 128'(msq_out), 128'(exp_msq));
                    if (pat == 0 || pat == 1)
                        check(mean_out == gen(pat, 0), "R4 full-scale mean", 128'(mean_out),
                              128'(gen(pat, 0)));
                    if (pat == 1)
                        check(msq_out == 64'h4000_0000_0000_0000, "R4 full-scale square",
                              128'(msq_out), 128'h4000_0000_0000_0000);
                end
                prev_done = window_done;
                @(negedge clk);
            end
            if (i == NS - 2) begin
                // R8: previous window's results still held mid-window
                check(mean_out == prev_mean, "R8 mean held", 128'(mean_out), 128'(prev_mean));
                check(msq_out == prev_msq, "R8 msq held", 128'(msq_out), 128'(prev_msq));
            end
        end
        check(seen == 1, "R5 one pulse per window", 128'(seen), 128'(1));
        // R7: results after the first window show the sums restarted at zero
        prev_mean = exp_mean;
        prev_msq  = exp_msq;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(mean_out == '0, "R1 mean reset", 128'(mean_out), 128'(0));
        check(msq_out == '0, "R1 msq reset", 128'(msq_out), 128'(0));
        check(!window_done, "R1 done reset", 128'(window_done), 128'(0));
        check(!busy, "R1 busy reset", 128'(busy), 128'(0));
        for (int w = 0; w < NWIN; w++)
            run_window(w); // windows after the full-scale ones also cover R7
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule